// File: doc/BRIEF.md
# Three-wire serial EEPROM device model

This block is a synthesizable slave that acts like a small three-wire (Microwire-style) serial EEPROM. It holds 64 words of 16 bits behind a 6-bit address. It runs on a fast system clock and oversamples the serial pins: chip select, the serial clock and serial data in. Every rising edge of the serial clock that it sees while chip select is high advances its instruction decoder by one bit.

An instruction is a start bit of 1, a 2-bit opcode and an address field, all sent MSB first. Two instructions then take 16 data bits. The model carries out word reads, word writes, word erase, erase of the whole array and write of the whole array. It also has two instructions that open and close a write-enable latch, and this latch gates every programming instruction. Erased words read back as all ones. The block is meant as a peer that a serial EEPROM master can be checked against in simulation or on a prototype.

Top module: `uwire_eeprom_model`

## Requirements
- R1: After reset, mw_do is low and the write-enable latch is cleared. A WRITE sent after reset and before any enable instruction leaves the addressed word unchanged.
- R2: While chip select is high and no instruction is in progress, serial-clock rising edges with data in low are ignored. The instruction starts at the first 1.
- R3: Opcode 10 is READ. After the last address bit the device drives a 0 on mw_do. On each of the next 16 serial-clock rising edges it drives the next bit of the addressed word, bit 15 first.
- R4: Opcode 01 is WRITE. The 6 address bits are followed by 16 data bits, MSB first, and with the latch set the word is stored at that address.
- R5: Opcode 11 is ERASE. With the latch set, the addressed word becomes 0xFFFF and no other word changes.
- R6: Opcode 00 with address bits [5:4] = 10 is ERAL. With the latch set, every word becomes 0xFFFF.
- R7: Opcode 00 with address bits [5:4] = 01 is WRAL. It is followed by 16 data bits, and with the latch set every word takes that value.
- R8: Opcode 00 with address bits [5:4] = 11 (EWEN) sets the write-enable latch, and 00 (EWDS) clears it. While the latch is clear, WRITE, ERASE, ERAL and WRAL change no word.
- R9: Driving chip select low aborts a partial instruction without side effects. The next instruction starting with a start bit decodes normally.
- R10: mw_do is low whenever the device is not shifting out read data: during instruction and address bits, and after the 16th read bit.
- R11: For opcode 00 instructions, address bits [3:0] are don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mw_cs | input | 1 | Serial chip select, active high |
| mw_clk | input | 1 | Serial clock; its rising edges shift bits |
| mw_di | input | 1 | Serial data into the device |
| mw_do | output | 1 | Serial data out of the device |

## Verification
The array is swept over all 64 addresses three times: after an erase of the whole array, after one write per address of an address-dependent pattern, and after a write of the whole array. Together these tell an address-decoding fault or a bit-order fault apart from a stuck data bit. Single-word erases at the lowest, highest and an inner address, each checked against its neighbour, separate word erase from whole-array erase. The programming instructions are each sent with the latch cleared, once by the disable instruction and once by reset, and the untouched data shows that the gate works. Instructions cut short by chip select, leading zeros before a start bit, and non-zero don't-care bits in the extended instructions each probe one decoder rule. Every read also checks the dummy zero and the low output around the data.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } uw_op_t;

  typedef enum logic [1:0] {
    EXT_LOCK   = 2'b00,
    EXT_FILL   = 2'b01,
    EXT_WIPE   = 2'b10,
    EXT_UNLOCK = 2'b11
  } uw_ext_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_DATA,
    S_READ,
    S_DONE
  } uw_state_t;

endpackage

// File: rtl/uwire_rst_sync.sv
module uwire_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/uwire_pin_sampler.sv
module uwire_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_in,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic cs_s,
  output logic sdi_s,
  output logic sclk_rise
);

  logic cs_q;
  logic sclk_q;
  logic sclk_prev_q;
  logic sdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b0;
      sclk_q      <= 1'b0;
      sclk_prev_q <= 1'b0;
      sdi_q       <= 1'b0;
    end else begin
      cs_q        <= cs_in;
      sclk_q      <= sclk_in;
      sclk_prev_q <= sclk_q;
      sdi_q       <= sdi_in;
    end
  end

  assign cs_s      = cs_q;
  assign sdi_s     = sdi_q;
  assign sclk_rise = sclk_q & ~sclk_prev_q;

endmodule

// File: rtl/uwire_word_array.sv
module uwire_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic word_en;
    assign word_en = we_all | (we_one & (waddr == ADDR_W'(g)));
    always_ff @(posedge clk) begin
      if (word_en) begin
        words_q[g] <= wdata;
      end
    end
  end

  assign rdata = words_q[raddr];

  AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_one, we_all})); // R7

endmodule

// File: rtl/uwire_decoder.sv
module uwire_decoder
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              we_one,
  output logic              we_all,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              sdo
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] READ_END  = CNT_W'(DATA_W);

  uw_state_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              wen_q, wen_d;
  logic              sdo_q, sdo_d;

  logic [ADDR_W-1:0] addr_shift;
  logic [DATA_W-1:0] data_shift;
  uw_op_t            op;
  uw_ext_t           ext;

  assign addr_shift = {addr_q[ADDR_W-2:0], sdi_s};
  assign data_shift = {data_q[DATA_W-2:0], sdi_s};
  assign op         = uw_op_t'(opc_q);
  assign ext        = uw_ext_t'(addr_shift[ADDR_W-1 -: 2]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    data_d  = data_q;
    wen_d   = wen_q;
    sdo_d   = sdo_q;
    we_one  = 1'b0;
    we_all  = 1'b0;
    waddr   = addr_q;
    wdata   = data_shift;
    raddr   = addr_shift;
    if (!cs_s) begin
      state_d = S_IDLE;
      cnt_d   = '0;
      sdo_d   = 1'b0;
    end else if (sclk_rise) begin
      unique case (state_q)
        S_IDLE: begin
          if (sdi_s) begin
            state_d = S_OPC;
            cnt_d   = '0;
          end
        end
        S_OPC: begin
          opc_d = {opc_q[0], sdi_s};
          if (cnt_q == CNT_W'(1)) begin
            state_d = S_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_ADDR: begin
          addr_d = addr_shift;
          if (cnt_q == ADDR_LAST) begin
            cnt_d = '0;
            unique case (op)
              OP_READ: begin
                state_d = S_READ;
                data_d  = rdata;
                sdo_d   = 1'b0;
              end
              OP_WRITE: state_d = S_DATA;
              OP_ERASE: begin
                we_one  = wen_q;
                waddr   = addr_shift;
                wdata   = '1;
                state_d = S_DONE;
              end
              OP_EXT: begin
                unique case (ext)
                  EXT_UNLOCK: begin
                    wen_d   = 1'b1;
                    state_d = S_DONE;
                  end
                  EXT_LOCK: begin
                    wen_d   = 1'b0;
                    state_d = S_DONE;
                  end
                  EXT_WIPE: begin
                    we_all  = wen_q;
                    wdata   = '1;
                    state_d = S_DONE;
                  end
                  EXT_FILL: state_d = S_DATA;
                  default:  state_d = S_DONE;
                endcase
              end
              default: state_d = S_DONE;
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          data_d = data_shift;
          if (cnt_q == DATA_LAST) begin
            state_d = S_DONE;
            cnt_d   = '0;
            if (op == OP_WRITE) begin
              we_one = wen_q;
            end else begin
              we_all = wen_q;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_READ: begin
          if (cnt_q == READ_END) begin
            state_d = S_DONE;
            sdo_d   = 1'b0;
          end else begin
            sdo_d  = data_q[DATA_W-1];
            data_d = {data_q[DATA_W-2:0], 1'b0};
            cnt_d  = cnt_q + 1'b1;
          end
        end
        S_DONE: begin
          state_d = S_DONE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wen_q   <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      wen_q   <= wen_d;
      sdo_q   <= sdo_d;
    end
  end

  assign sdo = sdo_q;

  AST_DO_LOW_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_READ) |-> !sdo_q); // R10

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (state_q == S_IDLE && !sdo_q)); // R9

  AST_LOCKED_NO_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> wen_q); // R8

  AST_ZERO_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sclk_rise && state_q == S_IDLE && !sdi_s) |=> state_q == S_IDLE); // R2

  AST_WRITE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> (sclk_rise && cs_s)); // R4

endmodule

// File: rtl/uwire_eeprom_model.sv
module uwire_eeprom_model #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mw_cs,
  input  logic mw_clk,
  input  logic mw_di,
  output logic mw_do
);

  logic              rst_int_n;
  logic              cs_s;
  logic              sdi_s;
  logic              sclk_rise;
  logic              we_one;
  logic              we_all;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  uwire_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  uwire_pin_sampler u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_in     (mw_cs),
    .sclk_in   (mw_clk),
    .sdi_in    (mw_di),
    .cs_s      (cs_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise)
  );

  uwire_decoder #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_s      (cs_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise),
    .rdata     (rdata),
    .raddr     (raddr),
    .we_one    (we_one),
    .we_all    (we_all),
    .waddr     (waddr),
    .wdata     (wdata),
    .sdo       (mw_do)
  );

  uwire_word_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_one (we_one),
    .we_all (we_all),
    .waddr  (waddr),
    .wdata  (wdata),
    .raddr  (raddr),
    .rdata  (rdata)
  );

endmodule

// File: tb/uwire_eeprom_model_tb.sv
module uwire_eeprom_model_tb_top;

  logic clk;
  logic rst_n;
  logic mw_cs;
  logic mw_clk;
  logic mw_di;
  logic mw_do;

  int checks;
  int failures;
  bit finished;

  uwire_eeprom_model dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mw_cs (mw_cs),
    .mw_clk(mw_clk),
    .mw_di (mw_di),
    .mw_do (mw_do)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    int v;
    v = (a * 40503 + 4660) ^ (a << 10);
    return v[15:0];
  endfunction

  task automatic sk_cycle(input logic b);
    @(negedge clk);
    mw_clk = 1'b0;
    mw_di  = b;
    repeat (4) @(negedge clk);
    mw_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk);
    mw_cs  = 1'b1;
    mw_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk);
    mw_clk = 1'b0;
    mw_di  = 1'b0;
    mw_cs  = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // send n bits of v MSB first; return 1 if mw_do stayed low (R10)
  task automatic send(input logic [31:0] v, input int n, output bit low);
    low = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      sk_cycle(v[i]);
      if (mw_do !== 1'b0) low = 1'b0;
    end
  endtask

  task automatic instr(input logic [31:0] v, input int n);
    bit low;
    cs_on();
    send(v, n, low);
    chk(low, "R10 low during command", {15'd0, ~low}, 16'd0);
    cs_off();
  endtask

  task automatic ewen(input logic [3:0] dc); instr({1'b1, 2'b00, 2'b11, dc}, 9); endtask
  task automatic ewds(input logic [3:0] dc); instr({1'b1, 2'b00, 2'b00, dc}, 9); endtask
  task automatic eral(input logic [3:0] dc); instr({1'b1, 2'b00, 2'b10, dc}, 9); endtask
  task automatic wral(input logic [15:0] d); instr({1'b1, 2'b00, 2'b01, 4'h0, d}, 25); endtask
  task automatic erase(input logic [5:0] a); instr({1'b1, 2'b11, a}, 9); endtask
  task automatic write(input logic [5:0] a, input logic [15:0] d);
    instr({1'b1, 2'b01, a, d}, 25);
  endtask

  // R3 READ: dummy 0 after the address, then 16 bits MSB first; R10 low after
  task automatic read_chk(input logic [5:0] a, input logic [15:0] exp,
                          input int zeros, input string req);
    bit low;
    logic dummy;
    logic [15:0] w;
    cs_on();
    for (int z = 0; z < zeros; z++) sk_cycle(1'b0);
    send({1'b1, 2'b10, a}, 9, low);
    dummy = mw_do;
    for (int i = 0; i < 16; i++) begin
      sk_cycle(1'b0);
      w = {w[14:0], mw_do};
    end
    sk_cycle(1'b0);
    chk(mw_do === 1'b0, "R10 low after read", {15'd0, mw_do}, 16'd0);
    chk(dummy === 1'b0 && low, "R3 dummy zero", {15'd0, dummy}, 16'd0);
    chk(w === exp, req, w, exp);
    cs_off();
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit low;
    checks   = 0;
    failures = 0;
    rst_n  = 1'b0;
    mw_cs  = 1'b0;
    mw_clk = 1'b0;
    mw_di  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mw_do === 1'b0, "R1 do low after reset", {15'd0, mw_do}, 16'd0);

    // R6 erase all, then sweep
    ewen(4'h0);
    eral(4'h0);
    for (int a = 0; a < 64; a++) read_chk(6'(a), 16'hFFFF, 0, "R6 ERAL sweep");

    // R4 write pattern everywhere, sweep
    for (int a = 0; a < 64; a++) write(6'(a), pat(a));
    for (int a = 0; a < 64; a++) read_chk(6'(a), pat(a), 0, "R4 WRITE sweep");

    // R5 word erase at boundaries, neighbours kept
    erase(6'd0);
    erase(6'd63);
    erase(6'd5);
    read_chk(6'd0, 16'hFFFF, 0, "R5 erase addr 0");
    read_chk(6'd63, 16'hFFFF, 0, "R5 erase addr 63");
    read_chk(6'd5, 16'hFFFF, 0, "R5 erase addr 5");
    read_chk(6'd6, pat(6), 0, "R5 neighbour 6 kept");
    read_chk(6'd1, pat(1), 0, "R5 neighbour 1 kept");
    read_chk(6'd62, pat(62), 0, "R5 neighbour 62 kept");

    // R8 with latch cleared, no programming; R11 don't-care bits
    ewds(4'b0101);
    write(6'd10, 16'h0000);
    erase(6'd11);
    eral(4'b1010);
    wral(16'h0000);
    read_chk(6'd10, pat(10), 0, "R8 WRITE blocked");
    read_chk(6'd11, pat(11), 0, "R8 ERASE blocked");
    read_chk(6'd12, pat(12), 0, "R8 ERAL/WRAL blocked");

    // R7 fill all with latch reopened (R11 non-zero low bits)
    ewen(4'b1010);
    wral(16'hA5C3);
    for (int a = 0; a < 64; a++) read_chk(6'(a), 16'hA5C3, 0, "R7 WRAL sweep R11");

    // R9 abort mid-data and mid-address
    cs_on();
    send({1'b1, 2'b01, 6'd3, 8'h00}, 17, low);
    cs_off();
    read_chk(6'd3, 16'hA5C3, 0, "R9 abort in data");
    cs_on();
    send({1'b1, 2'b11, 3'b000}, 6, low);
    cs_off();
    read_chk(6'd0, 16'hA5C3, 0, "R9 abort in address");
    write(6'd4, 16'h5A3C);
    read_chk(6'd4, 16'h5A3C, 0, "R9 decode after abort");

    // R2 leading zeros before start bit
    read_chk(6'd4, 16'h5A3C, 3, "R2 leading zeros read");
    cs_on();
    send({3'b000, 1'b1, 2'b01, 6'd7, 16'h1357}, 28, low);
    cs_off();
    read_chk(6'd7, 16'h1357, 0, "R2 leading zeros write");

    // R1 reset clears latch (array keeps contents)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mw_do === 1'b0, "R1 do low after second reset", {15'd0, mw_do}, 16'd0);
    write(6'd20, 16'h1111);
    read_chk(6'd20, 16'hA5C3, 0, "R1 latch cleared by reset");
    ewen(4'h0);
    write(6'd20, 16'h1111);
    read_chk(6'd20, 16'h1111, 0, "R8 EWEN reopens latch");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule